// File: doc/BRIEF.md
# Shared Bus Arbiter with Override

This block decides which of several masters owns a single on-chip bus. Master 0 is the configuration master, master 1 is the host bridge, and masters 2 and up are user-logic masters, one per `NUM_USER`. Each master raises its bit of the request vector and holds it for the whole transfer. The arbiter returns a one-hot grant and keeps it until the owner either pulses the transfer-complete input or drops its request. A burst in progress is therefore never taken away.

At each arbitration point the configuration master wins whenever it requests. It wins in every mode.

The remaining masters form a rotation ring in the order host, user 0, user 1, and so on. A two-bit mode input chooses how they share the bus:
- In plain rotation, the grant goes to the first requester at or after a pointer. The pointer then moves to the slot after the winner.
- In either fixed mode, one side (the host or the user group) is served before the other.
- In both fixed modes the user masters still take turns among themselves.

The grant is registered. It appears one clock after the cycle in which the decision was made.

Top module: `bus_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: At every arbitration point where `req[0]` is high, the next grant is `grant[0]`. Grants to the configuration master leave the rotation pointer where it was.
- R3: With `prio_mode` 2'b00 or 2'b11, the grant goes to the first requesting master at or after the pointer. The ring order is host (bit 1), then user bits 2 upward, then wrapping back to the host. After a grant, the pointer moves to the slot just past the winner.
- R4: With `prio_mode` 2'b01, a requesting host bridge is granted ahead of every user master.
- R5: With `prio_mode` 2'b10, the host bridge is granted only when no user master requests.
- R6: In both fixed modes (2'b01 and 2'b10), user masters are chosen by the same rotating pointer. The host slot is skipped when the pointer rests on it.
- R7: While the owner keeps its request high and `xfer_done` is low, `grant` does not change, whatever other requests arrive.
- R8: An arbitration point occurs when no grant is held, when the owner asserts `xfer_done`, or when the owner drops its request. If nothing is then requested, `grant` becomes all zero.
- R9: Cycles with no grant and no request leave the rotation pointer unchanged.
- R10: After a synchronous reset `grant` is zero and the pointer rests on the host bridge.
- R11: `grant` changes on the clock edge that follows the cycle in which the request or release is presented, never within that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_USER+2 | Requests: bit 0 configuration, bit 1 host bridge, bits 2 and up user masters |
| xfer_done | input | 1 | Current owner finishes its transfer in this cycle |
| prio_mode | input | 2 | 00/11 rotate, 01 host first, 10 users first |
| grant | output | NUM_USER+2 | Registered one-hot grant, same bit order as `req` |

## Verification
The bench builds the arbiter with `NUM_USER` = 3, giving five masters and a four-slot rotation ring. Three user slots are enough to show the pointer wrapping from the last user back to the host. They also show a non-requesting slot being skipped in the middle of the ring, and in the fixed modes the pointer resting on the masked host slot. Each scenario starts from reset, so the pointer position needed for every expected grant follows from the requirements alone.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    PM_ROTATE     = 2'b00,
    PM_HOST_FIRST = 2'b01,
    PM_USER_FIRST = 2'b10,
    PM_ROTATE_ALT = 2'b11
  } prio_mode_e;

endpackage

// File: rtl/bus_arb_pick.sv
// Rotating first-set search over the ring of non-configuration masters.
module bus_arb_pick #(
  parameter int NR = 4,
  localparam int PW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic [NR-1:0] mask,
  input  logic [PW-1:0] ptr,
  output logic          found,
  output logic [PW-1:0] sel
);

  always_comb begin
    int pos;
    found = 1'b0;
    sel   = '0;
    pos   = 0;
    for (int o = 0; o < NR; o++) begin
      pos = int'(ptr) + o;
      if (pos >= NR) pos = pos - NR;
      if (!found && mask[pos]) begin
        found = 1'b1;
        sel   = PW'(pos);
      end
    end
  end

endmodule

// File: rtl/bus_arb_ptr.sv
// Rotation pointer: the ring slot searched first at the next decision.
module bus_arb_ptr #(
  parameter int NR = 4,
  localparam int PW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [PW-1:0] winner,
  output logic [PW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (winner == PW'(NR - 1)) ? '0 : winner + PW'(1);
  end

  p_ptr_in_ring_r3: assert property (@(posedge clk) disable iff (rst)
    adv |=> (int'(ptr) < NR));

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter int NUM_USER = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_USER+1:0] req,
  input  logic                xfer_done,
  input  logic [1:0]          prio_mode,
  output logic [NUM_USER+1:0] grant
);

  localparam int NM = NUM_USER + 2;
  localparam int NR = NM - 1;
  localparam int PW = (NR > 1) ? $clog2(NR) : 1;

  logic [NR-1:0] ring_req, user_req, pick_mask, ring_onehot;
  logic [PW-1:0] ptr, sel;
  logic          found, owner_keep, decide;
  logic [NM-1:0] next_grant;

  assign ring_req   = req[NM-1:1];
  assign user_req   = ring_req & ~NR'(1);
  assign owner_keep = (|(grant & req)) && !xfer_done;
  assign decide     = !owner_keep;

  always_comb begin
    case (prio_mode_e'(prio_mode))
      PM_HOST_FIRST: pick_mask = ring_req[0] ? NR'(1) : user_req;
      PM_USER_FIRST: pick_mask = (|user_req) ? user_req : ring_req;
      default:       pick_mask = ring_req;
    endcase
  end

  bus_arb_pick #(.NR(NR)) u_pick (
    .mask  (pick_mask),
    .ptr   (ptr),
    .found (found),
    .sel   (sel)
  );

  bus_arb_ptr #(.NR(NR)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .adv    (decide && !req[0] && found),
    .winner (sel),
    .ptr    (ptr)
  );

  for (genvar g = 0; g < NR; g++) begin : g_onehot
    assign ring_onehot[g] = found && (sel == PW'(g));
  end

  assign next_grant = req[0] ? NM'(1) : {ring_onehot, 1'b0};

  always_ff @(posedge clk) begin
    if (rst)         grant <= '0;
    else if (decide) grant <= next_grant;
  end

  p_single_owner_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_cfg_override_r2: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req[0]) |=> grant[0]);

  p_no_preempt_r7: assert property (@(posedge clk) disable iff (rst)
    ((|(grant & req)) && !xfer_done) |=> $stable(grant));

  p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (grant == '0));

  p_host_first_r4: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && prio_mode == 2'b01 && req[1] && !req[0]) |=> grant[1]);

endmodule

// File: tb/bus_arbiter_test.sv
module bus_arbiter_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] req;
  logic       xfer_done;
  logic [1:0] prio_mode;
  logic [4:0] grant;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_arbiter #(.NUM_USER(3)) uut (
    .clk(clk), .rst(rst), .req(req), .xfer_done(xfer_done),
    .prio_mode(prio_mode), .grant(grant)
  );

  task automatic chk(input string tag, input logic [4:0] exp);
    vectors++;
    if (grant !== exp) begin
      miscompares++;
      $display("FAIL %s: grant=%b expected %b", tag, grant, exp);
    end
    vectors++;
    if (!$onehot0(grant)) begin
      miscompares++;
      $display("FAIL R1: grant=%b expected at most one bit set", grant);
    end
  endtask

  task automatic cyc(input logic [4:0] r, input logic d);
    @(negedge clk);
    req = r;
    xfer_done = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; req = '0; xfer_done = 1'b0; prio_mode = m;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 reset", 5'b00000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_timing();
    do_reset(2'b00);
    @(negedge clk);
    req = 5'b11110; xfer_done = 1'b0;
    #1;
    chk("R11 before edge", 5'b00000);
    @(posedge clk); #1;
    chk("R10 pointer at host", 5'b00010);
  endtask

  task automatic t_rotate();
    do_reset(2'b00);
    cyc(5'b11110, 0); chk("R3 first", 5'b00010);
    cyc(5'b11110, 0); chk("R7 hold", 5'b00010);
    cyc(5'b11110, 1); chk("R3 user0", 5'b00100);
    cyc(5'b11110, 1); chk("R3 user1", 5'b01000);
    cyc(5'b11110, 1); chk("R3 user2", 5'b10000);
    cyc(5'b11110, 1); chk("R3 wrap", 5'b00010);
    cyc(5'b10010, 1); chk("R3 skip", 5'b10000);
    cyc(5'b10010, 1); chk("R3 back to host", 5'b00010);
    do_reset(2'b11);
    cyc(5'b11110, 1); chk("R3 mode11 host", 5'b00010);
    cyc(5'b11110, 1); chk("R3 mode11 user0", 5'b00100);
  endtask

  task automatic t_config();
    do_reset(2'b00);
    cyc(5'b00100, 0); chk("R2 setup", 5'b00100);
    cyc(5'b00101, 0); chk("R7 no preempt", 5'b00100);
    cyc(5'b00101, 1); chk("R2 cfg wins", 5'b00001);
    cyc(5'b11111, 1); chk("R2 cfg again", 5'b00001);
    cyc(5'b11110, 1); chk("R2 pointer kept", 5'b01000);
    do_reset(2'b01);
    cyc(5'b00011, 0); chk("R2 over fixed", 5'b00001);
  endtask

  task automatic t_idle();
    do_reset(2'b00);
    cyc(5'b01000, 0); chk("R8 setup", 5'b01000);
    cyc(5'b00000, 1); chk("R8 release", 5'b00000);
    for (int i = 0; i < 3; i++) begin
      cyc(5'b00000, 0); chk("R9 idle", 5'b00000);
    end
    cyc(5'b11110, 0); chk("R9 pointer kept", 5'b10000);
    cyc(5'b00010, 0); chk("R8 drop", 5'b00010);
  endtask

  task automatic t_host_first();
    do_reset(2'b01);
    cyc(5'b11110, 1); chk("R4 host", 5'b00010);
    cyc(5'b11110, 1); chk("R4 host again", 5'b00010);
    cyc(5'b11100, 1); chk("R6 user0", 5'b00100);
    cyc(5'b11100, 1); chk("R6 user1", 5'b01000);
    cyc(5'b11110, 1); chk("R4 host returns", 5'b00010);
    cyc(5'b11100, 1); chk("R6 skip host slot", 5'b00100);
  endtask

  task automatic t_user_first();
    do_reset(2'b10);
    cyc(5'b00110, 0); chk("R5 user first", 5'b00100);
    cyc(5'b00010, 0); chk("R5 host alone", 5'b00010);
    cyc(5'b11110, 1); chk("R5 users over host", 5'b00100);
    cyc(5'b11110, 1); chk("R6 user1", 5'b01000);
    cyc(5'b11110, 1); chk("R6 user2", 5'b10000);
    cyc(5'b11110, 1); chk("R6 wrap skips host", 5'b00100);
  endtask

  initial begin
    rst = 1'b1; req = '0; xfer_done = 1'b0; prio_mode = 2'b00;
    t_reset_timing();
    t_rotate();
    t_config();
    t_idle();
    t_host_first();
    t_user_first();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run incomplete, expected to finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule